// File: doc/BRIEF.md
# I2C EEPROM Slave Protocol Engine

This block is the bus-facing protocol engine of a serial EEPROM with 1024 bytes of storage. It runs on a fast system clock and oversamples SCL and SDA, which are already filtered and clean. It pulls SDA low only through an open-drain enable. It finds START and STOP conditions and checks the device-select byte against a fixed type code and one strap pin. It then loads a word address and acknowledges each byte it accepts.

Reads are served from a memory read port through a 10-bit internal address register. Three read forms are supported:
- random reads, which set the address first;
- current-address reads, which continue from the last byte touched;
- sequential reads, where each master ACK fetches the next address.

Writes are not done here. Each accepted data byte goes to a separate page-write sequencer as a strobe carrying address and data. A STOP then commits the staged bytes, and a START discards them. While the sequencer reports busy, the engine acknowledges nothing. A master can therefore poll the select byte until the internal write has finished.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) abort any command at any point and release SDA on the next clock. After a START, the next 8 bits are taken as a new select byte.
- R2: A select byte is acknowledged only when its bits 7:4 equal 1010 and bit 3 equals `strap_a2`. Bits 2:1 give address bits 9:8. Bit 0 chooses the direction, with 1 meaning read. A mismatched byte is not acknowledged, and the bus is ignored until the next START.
- R3: For every accepted received byte (select, word address, write data), SDA is held low from the falling edge of the 8th clock to the falling edge of the 9th clock.
- R4: `sda_oe` changes only while SCL is low. Input bits are taken on SCL rising edges, and output bits change after SCL falling edges.
- R5: While `busy_i` is high, no byte is acknowledged, including the select byte.
- R6: A write select, a word address, a repeated START and a read select return the byte at {select bits 2:1, word address}.
- R7: After each byte sent, a master ACK (low) makes the engine send the byte at the next address. The 10-bit address wraps from 0x3FF to 0x000.
- R8: After a master NACK (high), SDA stays released until the next START or STOP.
- R9: A read select without a word address returns the byte at one past the last byte read or written.
- R10: A START or STOP during a read marks the address invalid. Current reads then return 0xFF until a word address is loaded again.
- R11: Each accepted write data byte pulses `wr_stb` with the byte and its address. Successive bytes advance only address bits 3:0, so 0x10F is followed by 0x100.
- R12: A STOP after at least one staged data byte pulses `wr_commit` once. A START in that situation pulses `wr_cancel` instead and commits nothing. A STOP with no data byte does neither.
- R13: After reset, `sda_oe` is 0, the address is 0x000 and valid, and no write pulse is active. SDA is never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_a2 | input | 1 | Device-address strap compared with select bit 3 |
| busy_i | input | 1 | Write sequencer busy; suppresses all acknowledges |
| mem_addr | output | ADDR_W | Read address to the memory array |
| mem_rdata | input | 8 | Read data at `mem_addr`, combinational |
| wr_stb | output | 1 | One-cycle pulse per accepted write data byte |
| wr_addr | output | ADDR_W | Address of the staged byte |
| wr_data | output | 8 | Staged byte |
| wr_commit | output | 1 | Pulse: start programming the staged bytes |
| wr_cancel | output | 1 | Pulse: drop the staged bytes |

## Verification
The bench builds the engine with its defaults: a 10-bit address, a 16-byte page and type code 1010. With these values, the 0x3FF to 0x000 wrap is reached in two short transactions. A four-byte page write starting at 0x10D crosses the in-page wrap. The bench models the sequencer's busy window as 400 cycles, long enough that a select sent right after a commit falls inside it. Strap mismatch, aborts in mid-select and mid-read, and a cancelled write are all run against that configuration.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADR,
      ST_WDAT,
      ST_ACK_DRV,
      ST_ACK_END,
      ST_RDAT,
      ST_RREL,
      ST_RSMP,
      ST_RNXT,
      ST_WAIT
   } ee_state_e;

endpackage

// File: rtl/i2cee_line_sense.sv
module i2cee_line_sense (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic ev_rise,
   output logic ev_fall,
   output logic ev_start,
   output logic ev_stop
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_lvl <= 1'b1;
         sda_lvl <= 1'b1;
         scl_p   <= 1'b1;
         sda_p   <= 1'b1;
      end else begin
         scl_lvl <= scl_i;
         sda_lvl <= sda_i;
         scl_p   <= scl_lvl;
         sda_p   <= sda_lvl;
      end
   end

   assign ev_rise  =  scl_lvl & ~scl_p;
   assign ev_fall  = ~scl_lvl &  scl_p;
   assign ev_start =  scl_lvl &  scl_p &  sda_p & ~sda_lvl;
   assign ev_stop  =  scl_lvl &  scl_p & ~sda_p &  sda_lvl;

endmodule

// File: rtl/i2cee_addr_reg.sv
module i2cee_addr_reg #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_hi,
   input  logic [ADDR_W-9:0]     hi_val,
   input  logic                  ld_lo,
   input  logic [7:0]            lo_val,
   input  logic                  inc_seq,
   input  logic                  inc_pg,
   input  logic                  invalidate,
   output logic [ADDR_W-1:0]     addr,
   output logic                  valid
);
   localparam logic [ADDR_W-1:0] A_ONE  = 1;
   localparam logic [PAGE_W-1:0] PG_ONE = 1;

   generate
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
         $error("PAGE_W must lie in 1..8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         valid <= 1'b1;
      end else begin
         if (ld_hi)   addr[ADDR_W-1:8] <= hi_val;
         if (ld_lo)   addr[7:0]        <= lo_val;
         if (inc_seq) addr             <= addr + A_ONE;
         if (inc_pg)  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PG_ONE;
         if (ld_lo)           valid <= 1'b1;
         else if (invalidate) valid <= 1'b0;
      end
   end

   assert_seq_wrap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_seq && addr == '1) |=> (addr == '0));

   assert_page_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (inc_pg && !ld_hi && !ld_lo) |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
   parameter int          ADDR_W    = 10,
   parameter int          PAGE_W    = 4,
   parameter logic [3:0]  DEV_ID    = 4'b1010,
   parameter logic [7:0]  FILL_BYTE = 8'hFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   output logic               sda_oe,
   input  logic               strap_a2,
   input  logic               busy_i,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [7:0]         mem_rdata,
   output logic               wr_stb,
   output logic [ADDR_W-1:0]  wr_addr,
   output logic [7:0]         wr_data,
   output logic               wr_commit,
   output logic               wr_cancel
);
   import i2cee_pkg::*;

   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 10) begin : g_bad_aw
         $error("ADDR_W must be 9 or 10: select byte carries at most two address bits");
      end
   endgenerate

   logic scl_lvl, sda_lvl, ev_rise, ev_fall, ev_start, ev_stop;

   i2cee_line_sense u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .ev_rise  (ev_rise),
      .ev_fall  (ev_fall),
      .ev_start (ev_start),
      .ev_stop  (ev_stop)
   );

   ee_state_e   st, nxt;
   logic [2:0]  cnt;
   logic [6:0]  sh;
   logic [7:0]  tx;
   logic        oe;
   logic        staged;

   logic [7:0]        byte_in;
   logic              last_bit, sel_ok, in_read, byte_done;
   logic              ld_hi, ld_lo, inc_seq, inc_pg, invalidate;
   logic [ADDR_W-1:0] cur_addr;
   logic              addr_valid;
   logic [7:0]        rd_byte;

   assign byte_in   = {sh, sda_lvl};
   assign last_bit  = (cnt == 3'd7);
   assign byte_done = ev_rise && last_bit;
   assign sel_ok    = (byte_in[7:4] == DEV_ID) && (byte_in[3] == strap_a2) && !busy_i;
   assign in_read   = (st == ST_RDAT) || (st == ST_RREL) || (st == ST_RSMP) || (st == ST_RNXT) ||
                      (((st == ST_ACK_DRV) || (st == ST_ACK_END)) && (nxt == ST_RDAT));

   always_comb begin
      ld_hi      = (st == ST_DEV)  && byte_done && sel_ok;
      ld_lo      = (st == ST_WADR) && byte_done && !busy_i;
      inc_pg     = (st == ST_WDAT) && byte_done && !busy_i;
      inc_seq    = (st == ST_RSMP) && ev_rise;
      invalidate = (ev_start || ev_stop) && in_read;
   end

   i2cee_addr_reg #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_hi      (ld_hi),
      .hi_val     (byte_in[HI_W:1]),
      .ld_lo      (ld_lo),
      .lo_val     (byte_in),
      .inc_seq    (inc_seq),
      .inc_pg     (inc_pg),
      .invalidate (invalidate),
      .addr       (cur_addr),
      .valid      (addr_valid)
   );

   assign mem_addr = cur_addr;
   assign rd_byte  = addr_valid ? mem_rdata : FILL_BYTE;
   assign sda_oe   = oe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         nxt       <= ST_IDLE;
         cnt       <= '0;
         sh        <= '0;
         tx        <= '0;
         oe        <= 1'b0;
         staged    <= 1'b0;
         wr_stb    <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         wr_commit <= 1'b0;
         wr_cancel <= 1'b0;
      end else begin
         wr_stb    <= 1'b0;
         wr_commit <= 1'b0;
         wr_cancel <= 1'b0;
         if (ev_start || ev_stop) begin
            oe     <= 1'b0;
            cnt    <= '0;
            staged <= 1'b0;
            if (ev_stop  && staged) wr_commit <= 1'b1;
            if (ev_start && staged) wr_cancel <= 1'b1;
            st <= ev_start ? ST_DEV : ST_IDLE;
         end else begin
            case (st)
               ST_DEV, ST_WADR, ST_WDAT: begin
                  if (ev_rise) begin
                     sh  <= byte_in[6:0];
                     cnt <= cnt + 3'd1;
                     if (last_bit) begin
                        if (st == ST_DEV) begin
                           if (sel_ok) begin
                              nxt <= byte_in[0] ? ST_RDAT : ST_WADR;
                              st  <= ST_ACK_DRV;
                           end else begin
                              st  <= ST_IDLE;
                           end
                        end else if (busy_i) begin
                           st <= ST_IDLE;
                        end else begin
                           nxt <= ST_WDAT;
                           st  <= ST_ACK_DRV;
                           if (st == ST_WDAT) begin
                              wr_stb  <= 1'b1;
                              wr_addr <= cur_addr;
                              wr_data <= byte_in;
                              staged  <= 1'b1;
                           end
                        end
                     end
                  end
               end
               ST_ACK_DRV: begin
                  if (ev_fall) begin
                     oe <= 1'b1;
                     st <= ST_ACK_END;
                  end
               end
               ST_ACK_END: begin
                  if (ev_fall) begin
                     cnt <= '0;
                     if (nxt == ST_RDAT) begin
                        tx <= rd_byte;
                        oe <= ~rd_byte[7];
                     end else begin
                        oe <= 1'b0;
                     end
                     st <= nxt;
                  end
               end
               ST_RDAT: begin
                  if (ev_rise) begin
                     cnt <= cnt + 3'd1;
                     if (last_bit) st <= ST_RREL;
                  end
                  if (ev_fall) begin
                     tx <= {tx[6:0], 1'b0};
                     oe <= ~tx[6];
                  end
               end
               ST_RREL: begin
                  if (ev_fall) begin
                     oe <= 1'b0;
                     st <= ST_RSMP;
                  end
               end
               ST_RSMP: begin
                  if (ev_rise) st <= sda_lvl ? ST_WAIT : ST_RNXT;
               end
               ST_RNXT: begin
                  if (ev_fall) begin
                     tx  <= rd_byte;
                     oe  <= ~rd_byte[7];
                     cnt <= '0;
                     st  <= ST_RDAT;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_abort_release_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start || ev_stop) |=> !sda_oe);

   assert_oe_scl_low_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

   assert_busy_no_ack_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ACK_DRV && $past(st) != ST_ACK_DRV) |-> !$past(busy_i));

   assert_nack_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> !sda_oe);

   assert_ack_drive_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> (st == ST_ACK_END || st == ST_RDAT));

endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
   localparam int AW       = 10;
   localparam int BUSY_CYC = 400;
   localparam int QTR      = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic busy = 1'b0;
   logic strap = 1'b1;
   logic sda_oe, wr_stb, wr_commit, wr_cancel;
   logic [AW-1:0] mem_addr, wr_addr;
   logic [7:0] wr_data, mem_rdata;
   logic sda_line;

   logic [7:0] mem [0:1023];
   assign mem_rdata = mem[mem_addr];
   assign sda_line  = sda_m & ~sda_oe;

   i2c_eeprom_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
      .strap_a2(strap), .busy_i(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_commit(wr_commit), .wr_cancel(wr_cancel)
   );

   int checks = 0, fails = 0, n_commit = 0, n_cancel = 0, busy_cnt = 0;
   bit done = 1'b0;
   logic [17:0] exp_wr[$];
   logic [17:0] stage[$];
   logic [7:0]  exp_rd[$];
   string       exp_tag[$];
   logic [7:0]  got_rd[$];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // sequencer model and scoreboard monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
         busy = 1'b0;
      end else begin
         if (wr_stb) begin
            stage.push_back({wr_addr, wr_data});
            if (exp_wr.size() == 0) chk(0, "R11 unexpected strobe", int'({wr_addr, wr_data}), 0);
            else begin
               logic [17:0] e;
               e = exp_wr.pop_front();
               chk({wr_addr, wr_data} == e, "R11 write strobe", int'({wr_addr, wr_data}), int'(e));
            end
         end
         if (wr_commit) begin
            n_commit++;
            foreach (stage[i]) mem[stage[i][17:8]] = stage[i][7:0];
            stage.delete();
            busy = 1'b1;
            busy_cnt = BUSY_CYC;
         end else if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) busy = 1'b0;
         end
         if (wr_cancel) begin
            n_cancel++;
            stage.delete();
         end
         while (got_rd.size() > 0 && exp_rd.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_rd.pop_front();
            e = exp_rd.pop_front();
            t = exp_tag.pop_front();
            chk(g == e, t, int'(g), int'(e));
         end
      end
   end

   task automatic wq();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic bitw(input logic b);
      sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bitr(output logic b);
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic sendb(input logic [7:0] v, output logic ack);
      for (int i = 7; i >= 0; i--) bitw(v[i]);
      bitr(ack);
   endtask

   task automatic recvb(input logic nack);
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) bitr(v[i]);
      bitw(nack);
      got_rd.push_back(v);
   endtask

   task automatic expect_rd(input logic [7:0] v, input string tag);
      exp_rd.push_back(v);
      exp_tag.push_back(tag);
   endtask

   function automatic logic [7:0] sel(input logic rd, input logic [1:0] pg);
      return {4'b1010, 1'b1, pg, rd};
   endfunction

   task automatic wait_idle();
      wq();
      while (busy) @(negedge clk);
      wq();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic a;
      logic [8:0] idle_bits;
      int c0;
      repeat (5) @(negedge clk);
      // R13 reset state
      chk(sda_oe == 1'b0, "R13 reset sda_oe", int'(sda_oe), 0);
      chk(mem_addr == '0, "R13 reset address", int'(mem_addr), 0);
      chk(wr_stb == 1'b0 && wr_commit == 1'b0, "R13 reset pulses", int'(wr_stb), 0);
      rst_n = 1'b1;
      wq();

      // R2 wrong type code, wrong strap bit
      bus_start(); sendb(8'b1011_1000, a); chk(a == 1'b1, "R2 wrong type nack", a, 1); bus_stop();
      bus_start(); sendb(8'b1010_0000, a); chk(a == 1'b1, "R2 strap mismatch nack", a, 1); bus_stop();

      // R1 abort in mid-select, then a fresh select is accepted
      bus_start(); bitw(1); bitw(0); bitw(1); bitw(0); bus_stop();
      bus_start(); sendb(sel(0, 2'd1), a); chk(a == 1'b0, "R1 select after abort", a, 0); bus_stop();
      wq();
      chk(n_commit == 0, "R12 stop without data no commit", n_commit, 0);

      // single byte write 0x101 = 77
      exp_wr.push_back({10'h101, 8'h77});
      bus_start(); sendb(sel(0, 2'd1), a); sendb(8'h01, a); sendb(8'h77, a);
      chk(a == 1'b0, "R3 data ack", a, 0);
      bus_stop(); wq();
      chk(n_commit == 1, "R12 commit on stop", n_commit, 1);
      wait_idle();

      // R11 page write crossing in-page wrap: 10D,10E,10F,100
      exp_wr.push_back({10'h10D, 8'hA0});
      exp_wr.push_back({10'h10E, 8'hA1});
      exp_wr.push_back({10'h10F, 8'hA2});
      exp_wr.push_back({10'h100, 8'hA3});
      bus_start();
      sendb(sel(0, 2'd1), a); chk(a == 1'b0, "R3 select ack", a, 0);
      sendb(8'h0D, a);        chk(a == 1'b0, "R3 word ack", a, 0);
      sendb(8'hA0, a); sendb(8'hA1, a); sendb(8'hA2, a); sendb(8'hA3, a);
      chk(a == 1'b0, "R3 last data ack", a, 0);
      bus_stop(); wq();
      chk(n_commit == 2, "R12 page commit", n_commit, 2);
      // R5 busy polling
      bus_start(); sendb(sel(0, 2'd1), a); chk(a == 1'b1, "R5 busy select nack", a, 1); bus_stop();
      wait_idle();
      bus_start(); sendb(sel(0, 2'd1), a); chk(a == 1'b0, "R5 ack after busy", a, 0); bus_stop();
      wq();

      // R9 current read after write continues at 0x101
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'h77, "R9 current read after write"); recvb(1'b1); bus_stop();

      // R6 random read with R7 sequential continuation
      bus_start(); sendb(sel(0, 2'd1), a); sendb(8'h0D, a);
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'hA0, "R6 random read");     recvb(1'b0);
      expect_rd(8'hA1, "R7 sequential 2nd");  recvb(1'b0);
      expect_rd(8'hA2, "R7 sequential 3rd");  recvb(1'b0);
      expect_rd(8'hFF, "R7 sequential 4th");  recvb(1'b1);
      bus_stop();
      // R9 after read
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'hFF, "R9 current read after read"); recvb(1'b1); bus_stop();

      // R7 wrap 0x3FF -> 0x000
      exp_wr.push_back({10'h3FF, 8'h5A});
      bus_start(); sendb(sel(0, 2'd3), a); sendb(8'hFF, a); sendb(8'h5A, a); bus_stop();
      wait_idle();
      exp_wr.push_back({10'h000, 8'hC3});
      bus_start(); sendb(sel(0, 2'd0), a); sendb(8'h00, a); sendb(8'hC3, a); bus_stop();
      wait_idle();
      bus_start(); sendb(sel(0, 2'd3), a); sendb(8'hFF, a);
      bus_start(); sendb(sel(1, 2'd3), a);
      expect_rd(8'h5A, "R6 read at 0x3FF"); recvb(1'b0);
      expect_rd(8'hC3, "R7 wrap to 0x000"); recvb(1'b1);
      // R8 after NACK the line stays released
      for (int i = 8; i >= 0; i--) bitr(idle_bits[i]);
      chk(idle_bits == 9'h1FF, "R8 released after nack", int'(idle_bits), 'h1FF);
      bus_stop();

      // R10 aborted read invalidates the address
      bus_start(); sendb(sel(0, 2'd1), a); sendb(8'h0D, a); bus_stop();
      bus_start(); sendb(sel(1, 2'd1), a); chk(a == 1'b0, "R10 read select ack", a, 0);
      bus_stop();
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'hFF, "R10 invalid read 1"); recvb(1'b1); bus_stop();
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'hFF, "R10 invalid read 2"); recvb(1'b1); bus_stop();
      bus_start(); sendb(sel(0, 2'd1), a); sendb(8'h0D, a);
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'hA0, "R10 reload by random read"); recvb(1'b1); bus_stop();
      bus_start(); sendb(sel(1, 2'd1), a);
      expect_rd(8'hA1, "R10 current read valid again"); recvb(1'b1); bus_stop();

      // R12 cancel by repeated START
      c0 = n_commit;
      exp_wr.push_back({10'h220, 8'h99});
      bus_start(); sendb(sel(0, 2'd2), a); sendb(8'h20, a); sendb(8'h99, a);
      bus_start(); bus_stop(); wq();
      chk(n_cancel == 1, "R12 cancel pulse", n_cancel, 1);
      chk(n_commit == c0, "R12 no commit after cancel", n_commit, c0);
      chk(busy == 1'b0, "R12 no busy after cancel", int'(busy), 0);
      bus_start(); sendb(sel(0, 2'd2), a); sendb(8'h20, a);
      bus_start(); sendb(sel(1, 2'd2), a);
      expect_rd(8'hFF, "R12 cancelled byte not written"); recvb(1'b1); bus_stop();

      repeat (20) @(negedge clk);
      chk(exp_rd.size() == 0, "R6 all reads observed", exp_rd.size(), 0);
      chk(exp_wr.size() == 0, "R11 all strobes observed", exp_wr.size(), 0);
      chk(sda_oe == 1'b0, "R13 idle released", int'(sda_oe), 0);
      finish_run();
   end
endmodule